// File: doc/BRIEF.md
# Trace Message Capture Queue

The block sits on the write side of a trace path. System bus writes that land in a fixed address window are turned into trace messages and queued for a serializer further down the path. Each word-aligned address in the window selects one of 256 channels. A message carries the channel, the initiator that issued the write, an end-of-message marker, a code for the size of the write taken from the byte enables, and the write data. It also carries a flag that is set when the channel is the same as the channel of the message captured just before it. The serializer uses that flag to leave the channel address out of the serial stream.

The queue never loses a message. When it is full, the bus write is held off by keeping `wr_ready` low until an entry drains. The serializer takes entries through a valid/ready handshake. It reports with `ser_busy` that its shift register still holds data, and the block folds that into a single `fifo_empty` status.

A small state machine follows the compression context. CAP_OFF is held while the block is disabled and is entered from any state when `enable` is low. From CAP_OFF, a cycle with `enable` high moves to CAP_LINKED if a message is captured in that cycle and to CAP_FRESH otherwise. CAP_FRESH (enabled, with no previous channel) moves to CAP_LINKED on the first captured message. CAP_LINKED (a previous channel is held) stays there until `enable` drops. Only CAP_LINKED can produce a compressed message.

Top module: `trace_msg_capture`

## Requirements
- R1: The size code in `msg_size` depends on the highest enabled byte lane. Lane 0 gives 0 (1 byte), lane 1 gives 1 (2 bytes), and lane 2 or 3 gives 3 (4 bytes). Code 2 never appears. The channel, data, initiator and marker bits are passed through unchanged.
- R2: `msg_comp` is 1 when a message's channel equals the channel of the previously captured message, and 0 otherwise.
- R3: The channel comparison ignores `wr_cpu`. Back-to-back writes to one channel from different initiators still set `msg_comp`.
- R4: The first message after reset, and the first message after `enable` has been low for at least one clock edge, has `msg_comp` = 0.
- R5: A write in the window whose byte enables are all zero is acknowledged in its own cycle. It creates no message and leaves the compression context unchanged.
- R6: When the queue holds DEPTH entries, a message-producing write sees `wr_ready` low. It is accepted once an entry has been popped. No message is lost and the order is kept.
- R7: A message accepted on a clock edge is presented on `msg_valid` right after that edge. Messages leave in acceptance order.
- R8: `fifo_empty` is 1 only when the queue holds no entry and `ser_busy` is low.
- R9: A write is in the window when `wr_addr[15:10]` equals 6'b010000 and `wr_addr[1:0]` is 0. The channel is `wr_addr[9:2]`. Writes outside the window are acknowledged at once, create no message and leave the compression context unchanged.
- R10: While `enable` is low, every write is acknowledged at once and no message is created.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Capture enable; low clears the compression context |
| wr_valid | input | 1 | Bus write request |
| wr_ready | output | 1 | Bus write acknowledge |
| wr_addr | input | 16 | Byte address of the write |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| wr_cpu | input | 1 | Initiator of the write (0 or 1) |
| wr_eom | input | 1 | End-of-message / timestamp marker |
| msg_valid | output | 1 | Head entry present |
| msg_ready | input | 1 | Serializer takes the head entry |
| msg_eom | output | 1 | Marker bit of the head entry |
| msg_cpu | output | 1 | Initiator bit of the head entry |
| msg_chan | output | 8 | Channel number of the head entry |
| msg_size | output | 2 | Size code of the head entry |
| msg_data | output | 32 | Data of the head entry |
| msg_comp | output | 1 | Channel may be left out (same as previous) |
| ser_busy | input | 1 | Serializer shift register still holds data |
| fifo_empty | output | 1 | Nothing left to export |

## Verification
Channel sequences are built to separate the compression cases. They include a repeated channel, a repeat from the other initiator, a new channel followed by a return to the old one, and a repeat split by a zero-enable write, an out-of-window write or a disable period. Only the split by a disable period may clear the flag. Byte-enable patterns with the highest lane at each of the four positions, including a non-contiguous one, tell apart the three size codes. A burst with the sink stalled fills the queue, holds the bus off and then releases it, which shows that nothing is lost or reordered. Toggling `ser_busy` over an empty queue separates the two terms of the empty status.

// File: rtl/tmsg_pkg.sv
`timescale 1ns/1ps
package tmsg_pkg;
    localparam int CHAN_W = 8;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [SIZE_W-1:0] SZ_ONE  = 2'd0;
    localparam logic [SIZE_W-1:0] SZ_TWO  = 2'd1;
    localparam logic [SIZE_W-1:0] SZ_FOUR = 2'd3;

    typedef struct packed {
        logic              eom;
        logic              cpu;
        logic [CHAN_W-1:0] chan;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] data;
        logic              comp;
    } tmsg_t;

    typedef enum logic [1:0] {
        CAP_OFF    = 2'd0,
        CAP_FRESH  = 2'd1,
        CAP_LINKED = 2'd2
    } cap_state_e;
endpackage

// File: rtl/tmsg_be_encoder.sv
`timescale 1ns/1ps
module tmsg_be_encoder
    import tmsg_pkg::*;
#(
    parameter int LANES = BE_W
) (
    input  logic [LANES-1:0]  be,
    output logic              any_lane,
    output logic [SIZE_W-1:0] size
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDX_W-1:0] top_lane;

    always_comb begin
        top_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) top_lane = IDX_W'(i);
        end
    end

    always_comb begin
        any_lane = |be;
        if (top_lane == IDX_W'(0))      size = SZ_ONE;
        else if (top_lane == IDX_W'(1)) size = SZ_TWO;
        else                            size = SZ_FOUR;
    end

    always_comb begin
        if (any_lane) begin
            assert (size != 2'd2) else $error("AST_SIZE_CODE_LEGAL"); // R1
        end
    end
endmodule

// File: rtl/tmsg_fifo.sv
`timescale 1ns/1ps
module tmsg_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 45
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [W-1:0]                 in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [W-1:0]                 out_data,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign in_ready  = (count != FULL);
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign level     = count;
    assign do_push   = in_valid && in_ready;
    assign do_pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL) else $error("AST_NO_OVERFLOW"); // R6

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("AST_HEAD_HELD"); // R7
endmodule

// File: rtl/tmsg_capture_fsm.sv
`timescale 1ns/1ps
module tmsg_capture_fsm
    import tmsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              push_fire,
    input  logic [CHAN_W-1:0] chan,
    output logic              comp
);
    cap_state_e        state, state_nx;
    logic [CHAN_W-1:0] last_chan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         last_chan <= '0;
        else if (push_fire) last_chan <= chan;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_OFF: begin
                if (enable) state_nx = push_fire ? CAP_LINKED : CAP_FRESH;
            end
            CAP_FRESH: begin
                if (!enable)        state_nx = CAP_OFF;
                else if (push_fire) state_nx = CAP_LINKED;
            end
            CAP_LINKED: begin
                if (!enable) state_nx = CAP_OFF;
            end
            default: state_nx = CAP_OFF;
        endcase
    end

    always_comb begin
        comp = 1'b0;
        unique case (state)
            CAP_LINKED: comp = (chan == last_chan);
            default:    comp = 1'b0;
        endcase
    end

    AST_FIRST_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable) && push_fire) |-> !comp)
        else $error("AST_FIRST_AFTER_OFF"); // R4

    AST_NO_PUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !push_fire) else $error("AST_NO_PUSH_WHEN_OFF"); // R10
endmodule

// File: rtl/trace_msg_capture.sv
`timescale 1ns/1ps
module trace_msg_capture
    import tmsg_pkg::*;
#(
    parameter int              DEPTH    = 8,
    parameter int              ADDR_W   = 16,
    parameter logic [15:0]     WIN_BASE = 16'h4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BE_W-1:0]     wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_cpu,
    input  logic                wr_eom,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic                msg_eom,
    output logic                msg_cpu,
    output logic [CHAN_W-1:0]   msg_chan,
    output logic [SIZE_W-1:0]   msg_size,
    output logic [DATA_W-1:0]   msg_data,
    output logic                msg_comp,
    input  logic                ser_busy,
    output logic                fifo_empty
);
    localparam int CH_LSB  = $clog2(BE_W);
    localparam int WIN_LSB = CH_LSB + CHAN_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ENT_W   = $bits(tmsg_t);

    logic              in_window, any_lane, wants_msg, push_fire, comp;
    logic              q_in_ready;
    logic [CHAN_W-1:0] chan;
    logic [SIZE_W-1:0] size;
    logic [CNT_W-1:0]  level;
    tmsg_t             entry_in, entry_out;
    logic [ENT_W-1:0]  head_bits;

    assign in_window = (wr_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB])
                    && (wr_addr[CH_LSB-1:0] == '0);
    assign chan      = wr_addr[WIN_LSB-1:CH_LSB];
    assign wants_msg = enable && in_window && any_lane;
    assign wr_ready  = !wants_msg || q_in_ready;
    assign push_fire = wr_valid && wants_msg && q_in_ready;

    tmsg_be_encoder #(.LANES(BE_W)) u_enc (
        .be       (wr_be),
        .any_lane (any_lane),
        .size     (size)
    );

    tmsg_capture_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .push_fire (push_fire),
        .chan      (chan),
        .comp      (comp)
    );

    always_comb begin
        entry_in.eom  = wr_eom;
        entry_in.cpu  = wr_cpu;
        entry_in.chan = chan;
        entry_in.size = size;
        entry_in.data = wr_data;
        entry_in.comp = comp;
    end

    tmsg_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (wr_valid && wants_msg),
        .in_ready  (q_in_ready),
        .in_data   (entry_in),
        .out_valid (msg_valid),
        .out_ready (msg_ready),
        .out_data  (head_bits),
        .level     (level)
    );

    assign entry_out  = tmsg_t'(head_bits);
    assign msg_eom    = entry_out.eom;
    assign msg_cpu    = entry_out.cpu;
    assign msg_chan   = entry_out.chan;
    assign msg_size   = entry_out.size;
    assign msg_data   = entry_out.data;
    assign msg_comp   = entry_out.comp;
    assign fifo_empty = (level == '0) && !ser_busy;

    AST_ZERO_BE_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_be == '0) |-> wr_ready)
        else $error("AST_ZERO_BE_NO_MSG"); // R5

    AST_ZERO_BE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_be == '0) |=> (level <= $past(level)))
        else $error("AST_ZERO_BE_NO_GROWTH"); // R5

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH) && wr_valid && wants_msg) |-> !wr_ready)
        else $error("AST_STALL_WHEN_FULL"); // R6

    AST_EMPTY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (!msg_valid && !ser_busy))
        else $error("AST_EMPTY_STATUS"); // R8

    AST_OFF_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && wr_valid) |-> wr_ready)
        else $error("AST_OFF_ACK"); // R10
endmodule

// File: tb/tb_trace_msg_capture.sv
`timescale 1ns/1ps
module tb_trace_msg_capture;
    import tmsg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        wr_valid;
    logic        wr_ready;
    logic [15:0] wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic        wr_cpu;
    logic        wr_eom;
    logic        msg_valid;
    logic        msg_ready;
    logic        msg_eom;
    logic        msg_cpu;
    logic [7:0]  msg_chan;
    logic [1:0]  msg_size;
    logic [31:0] msg_data;
    logic        msg_comp;
    logic        ser_busy;
    logic        fifo_empty;

    int checks = 0;
    int errors = 0;
    int got_msgs = 0;
    int exp_msgs = 0;

    tmsg_t exp_q[$];
    string tag_q[$];
    bit        m_last_v = 1'b0;
    bit [7:0]  m_last_c = '0;
    bit        m_en = 1'b0;

    always #2.5 clk = ~clk;

    trace_msg_capture dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .wr_cpu(wr_cpu), .wr_eom(wr_eom),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_eom(msg_eom),
        .msg_cpu(msg_cpu), .msg_chan(msg_chan), .msg_size(msg_size),
        .msg_data(msg_data), .msg_comp(msg_comp),
        .ser_busy(ser_busy), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] chan_addr(input logic [7:0] c);
        return {6'b010000, c, 2'b00};
    endfunction

    // Driver: computes the expected message and hands it to the scoreboard.
    task automatic do_write(input logic [15:0] addr, input logic [3:0] be,
                            input logic cpu, input logic eom,
                            input logic [31:0] data, input string req);
        bit    in_win;
        bit    makes;
        tmsg_t e;
        logic [1:0] sz;
        in_win = (addr[15:10] == 6'b010000) && (addr[1:0] == 2'b00);
        makes  = m_en && in_win && (be != 4'b0);
        if (be[3] || be[2]) sz = 2'd3;
        else if (be[1])     sz = 2'd1;
        else                sz = 2'd0;
        if (makes) begin
            e.eom  = eom;
            e.cpu  = cpu;
            e.chan = addr[9:2];
            e.size = sz;
            e.data = data;
            e.comp = m_last_v && (m_last_c == addr[9:2]);
            exp_q.push_back(e);
            tag_q.push_back(req);
            exp_msgs++;
            m_last_v = 1'b1;
            m_last_c = addr[9:2];
        end
        @(negedge clk);
        wr_addr  = addr;
        wr_be    = be;
        wr_cpu   = cpu;
        wr_eom   = eom;
        wr_data  = data;
        wr_valid = 1'b1;
        #1;
        if (!makes) chk(wr_ready == 1'b1, req, "immediate ack", wr_ready, 1);
        while (!wr_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        enable = v;
        m_en   = v;
        if (!v) m_last_v = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares each popped entry with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && msg_valid && msg_ready) begin
                tmsg_t g;
                g.eom  = msg_eom;
                g.cpu  = msg_cpu;
                g.chan = msg_chan;
                g.size = msg_size;
                g.data = msg_data;
                g.comp = msg_comp;
                got_msgs++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R9/R10", "unexpected message", 64'(g), 0);
                end else begin
                    tmsg_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(g == e, t, "message content", 64'(g), 64'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; wr_valid = 1'b0; wr_addr = '0;
        wr_be = '0; wr_data = '0; wr_cpu = 1'b0; wr_eom = 1'b0;
        msg_ready = 1'b1; ser_busy = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(fifo_empty == 1'b1, "R8", "reset empty", fifo_empty, 1);
        chk(msg_valid == 1'b0, "R7", "reset valid", msg_valid, 0);
        chk(wr_ready == 1'b1, "R10", "reset ack", wr_ready, 1);

        set_enable(1'b1);
        // R4 first message, R1 sizes, R7 latency
        do_write(chan_addr(8'h03), 4'b1111, 1'b0, 1'b1, 32'hA0A0_0001, "R4");
        chk(msg_valid == 1'b1, "R7", "valid after accept", msg_valid, 1);
        do_write(chan_addr(8'h03), 4'b0011, 1'b1, 1'b0, 32'hA0A0_0002, "R3");
        do_write(chan_addr(8'h03), 4'b0001, 1'b0, 1'b0, 32'hA0A0_0003, "R2");
        do_write(chan_addr(8'h04), 4'b0100, 1'b1, 1'b1, 32'hA0A0_0004, "R1");
        do_write(chan_addr(8'h03), 4'b1000, 1'b0, 1'b0, 32'hA0A0_0005, "R2");
        do_write(chan_addr(8'h03), 4'b0101, 1'b1, 1'b0, 32'hA0A0_0006, "R1");

        // R5 zero byte enables keep context
        do_write(chan_addr(8'h07), 4'b1111, 1'b0, 1'b0, 32'hB0B0_0001, "R5");
        do_write(chan_addr(8'h08), 4'b0000, 1'b0, 1'b0, 32'hB0B0_0002, "R5");
        do_write(chan_addr(8'h07), 4'b0011, 1'b1, 1'b0, 32'hB0B0_0003, "R5");

        // R9 outside window
        do_write(16'h8000, 4'b1111, 1'b0, 1'b0, 32'hC0C0_0001, "R9");
        do_write(chan_addr(8'h09) | 16'h0001, 4'b1111, 1'b0, 1'b0, 32'hC0C0_0002, "R9");
        do_write(chan_addr(8'h07), 4'b1111, 1'b0, 1'b0, 32'hC0C0_0003, "R9");

        // R10 disabled, R4 after re-enable
        set_enable(1'b0);
        do_write(chan_addr(8'h07), 4'b1111, 1'b0, 1'b0, 32'hD0D0_0001, "R10");
        set_enable(1'b1);
        do_write(chan_addr(8'h07), 4'b1111, 1'b1, 1'b0, 32'hD0D0_0002, "R4");

        // R6 fill the queue with the sink stalled
        repeat (4) @(negedge clk);
        msg_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            do_write(chan_addr(8'h10 + 8'(i % 3)), 4'b1111, 1'(i), 1'b0,
                     32'hE0E0_0000 + 32'(i), "R6");
        end
        @(negedge clk);
        wr_addr = chan_addr(8'h20); wr_be = 4'b1111; wr_valid = 1'b1;
        #1;
        chk(wr_ready == 1'b0, "R6", "stall when full", wr_ready, 0);
        chk(fifo_empty == 1'b0, "R8", "not empty when full", fifo_empty, 0);
        @(negedge clk);
        #1;
        chk(wr_ready == 1'b0, "R6", "stall held", wr_ready, 0);
        wr_valid = 1'b0;
        msg_ready = 1'b1;
        do_write(chan_addr(8'h20), 4'b1111, 1'b0, 1'b1, 32'hE0E0_00FF, "R6");
        do_write(chan_addr(8'h20), 4'b0001, 1'b1, 1'b0, 32'hE0E0_0100, "R6");
        repeat (20) @(negedge clk);

        // R8 busy serializer keeps status low
        ser_busy = 1'b1;
        #1;
        chk(msg_valid == 1'b0, "R8", "drained", msg_valid, 0);
        chk(fifo_empty == 1'b0, "R8", "busy serializer", fifo_empty, 0);
        @(negedge clk);
        ser_busy = 1'b0;
        #1;
        chk(fifo_empty == 1'b1, "R8", "idle and empty", fifo_empty, 1);

        chk(exp_q.size() == 0, "R6", "messages left unseen", exp_q.size(), 0);
        chk(got_msgs == exp_msgs, "R7", "message count", got_msgs, exp_msgs);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule